// File: doc/BRIEF.md
# Ring Buffer Fetch Controller

This block sits between a host that produces commands into a circular buffer in memory and a unit that consumes them one 32-bit word at a time. It keeps the ring description (start address, size as a power of two, and two 64-bit pointers). While the consume pointer differs from the produce pointer, it issues one word read at a time to a memory port. Each returned word is handed to the consumer, the consume pointer is bumped, and its low word is posted to a shared memory slot so the host can see progress.

The host moves the produce pointer in one of two ways. In register mode it writes the low half into a staging register and then the high half, which commits all 64 bits at once. In doorbell mode a single 64-bit doorbell write carrying the configured index replaces the pointer. Register writes to the pointer are then dropped.

Top module: `ring_fetch_ctrl`

## Requirements
- R1: After reset both pointers, the start address and the size exponent are zero, `empty` is high, and `req_valid` and `wb_valid` are low.
- R2: `empty` is high exactly when `rptr` equals `wptr`. A fetch is started only from idle while they differ.
- R3: With the doorbell disabled, a write to register 3 only stages the low 32 bits and leaves `wptr` unchanged. A write to register 4 sets `wptr` to {register-4 data, staged low half} in the following cycle.
- R4: Register 7 bit 16 enables the doorbell, and bits [DBW-1:0] hold its index. With the doorbell enabled, `db_valid` with a matching `db_index` loads `db_data` into `wptr`. A mismatched index, or any doorbell while it is disabled, leaves `wptr` unchanged.
- R5: While the doorbell is enabled, writes to registers 3 and 4 do not change `wptr`.
- R6: The fetch address is start + 4 × (`rptr` mod 2^k). The start address is written through register 0 (bits 31:0) and register 1 (the upper AW-32 bits), and k is written through register 2 (bits LGW-1:0).
- R7: At most one fetch is outstanding. `req_valid` and `req_addr` hold steady until `req_ready` accepts the request.
- R8: `rptr` increases by exactly one on each response handshake (`rsp_valid` and `rsp_ready`) and never changes otherwise.
- R9: The cycle after each advance, `wb_valid` is high for one cycle. `wb_data` carries the low 32 bits of the new `rptr`, and `wb_addr` carries the slot address from registers 5 (bits 31:0) and 6 (the upper bits).
- R10: Only while a response is awaited, `cmd_valid` follows `rsp_valid`, `cmd_data` follows `rsp_data`, and `rsp_ready` follows `cmd_ready`. At all other times `cmd_valid` and `rsp_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| db_valid | input | 1 | Doorbell write strobe |
| db_index | input | DBW | Doorbell index |
| db_data | input | 64 | Doorbell pointer value |
| req_valid | output | 1 | Fetch request valid |
| req_ready | input | 1 | Fetch request accepted |
| req_addr | output | AW | Byte address of the word to fetch |
| rsp_valid | input | 1 | Fetch response valid |
| rsp_ready | output | 1 | Fetch response accepted |
| rsp_data | input | 32 | Fetched word |
| cmd_valid | output | 1 | Word offered to consumer |
| cmd_ready | input | 1 | Consumer takes the word |
| cmd_data | output | 32 | Word to consumer |
| wb_valid | output | 1 | Read-pointer writeback strobe |
| wb_addr | output | AW | Writeback slot address |
| wb_data | output | 32 | Low word of the read pointer |
| wptr | output | 64 | Committed write pointer |
| rptr | output | 64 | Read pointer |
| empty | output | 1 | Pointers equal |

## Verification
The bench uses the default AW=40, so the start and slot addresses are split across two register writes and the upper part is only 8 bits wide. It also uses DBW=8. At run time it programs ring sizes of 8 and then 4 words, so the modulo wrap of the fetch address occurs many times within a few dozen fetches. The memory side accepts and answers with varying stalls, which exercises the hold-until-accepted rule and the single-outstanding rule.

// File: rtl/ring_fetch_ctrl.sv
module ring_fetch_ctrl #(
  parameter int AW  = 40,
  parameter int DBW = 8,
  parameter int LGW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [2:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  input  logic           db_valid,
  input  logic [DBW-1:0] db_index,
  input  logic [63:0]    db_data,
  output logic           req_valid,
  input  logic           req_ready,
  output logic [AW-1:0]  req_addr,
  input  logic           rsp_valid,
  output logic           rsp_ready,
  input  logic [31:0]    rsp_data,
  output logic           cmd_valid,
  input  logic           cmd_ready,
  output logic [31:0]    cmd_data,
  output logic           wb_valid,
  output logic [AW-1:0]  wb_addr,
  output logic [31:0]    wb_data,
  output logic [63:0]    wptr,
  output logic [63:0]    rptr,
  output logic           empty
);
  localparam int HW = AW - 32;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;
  state_t state;

  logic [AW-1:0]  base;
  logic [LGW-1:0] lg;
  logic [31:0]    lo_stage;
  logic           db_en;
  logic [DBW-1:0] db_id;

  logic [63:0] offs;
  logic        rsp_hs;

  assign empty     = (rptr == wptr);
  assign offs      = rptr & ((64'd1 << lg) - 64'd1);
  assign rsp_ready = cmd_ready && (state == S_WAIT);
  assign cmd_valid = rsp_valid && (state == S_WAIT);
  assign cmd_data  = rsp_data;
  assign req_valid = (state == S_REQ);
  assign rsp_hs    = rsp_valid && rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0; lg <= '0; lo_stage <= '0; wptr <= '0;
      wb_addr <= '0; db_en <= 1'b0; db_id <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          3'd0: base[31:0]    <= reg_wdata;
          3'd1: base[AW-1:32] <= reg_wdata[HW-1:0];
          3'd2: lg            <= reg_wdata[LGW-1:0];
          3'd3: if (!db_en) lo_stage <= reg_wdata;
          3'd4: if (!db_en) wptr     <= {reg_wdata, lo_stage};
          3'd5: wb_addr[31:0]    <= reg_wdata;
          3'd6: wb_addr[AW-1:32] <= reg_wdata[HW-1:0];
          default: begin
            db_en <= reg_wdata[16];
            db_id <= reg_wdata[DBW-1:0];
          end
        endcase
      end
      if (db_valid && db_en && db_index == db_id) wptr <= db_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; rptr <= '0; req_addr <= '0;
      wb_valid <= 1'b0; wb_data <= '0;
    end else begin
      wb_valid <= 1'b0;
      case (state)
        S_IDLE: if (!empty) begin
          state    <= S_REQ;
          req_addr <= base + AW'(offs << 2);
        end
        S_REQ: if (req_ready) state <= S_WAIT;
        default: if (rsp_hs) begin
          state    <= S_IDLE;
          rptr     <= rptr + 64'd1;
          wb_valid <= 1'b1;
          wb_data  <= 32'(rptr + 64'd1);
        end
      endcase
    end
  end

  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));
  a_r8_rptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> rptr == $past(rptr) + 64'd1);
  a_r8_rptr_still: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rsp_ready) |=> $stable(rptr));
  a_r3_lo_invisible: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 3'd3 && !db_valid |=> $stable(wptr));
  a_r9_wb_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(rsp_valid && rsp_ready));
  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && (rsp_valid && rsp_ready)));
endmodule

// File: tb/test_ring_fetch_ctrl.sv
module test_ring_fetch_ctrl;
  localparam int AW = 40, DBW = 8, LGW = 5;
  localparam longint AMASK = (64'd1 << AW) - 1;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [2:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic db_valid = 0; logic [DBW-1:0] db_index = 0; logic [63:0] db_data = 0;
  logic req_valid, req_ready = 0; logic [AW-1:0] req_addr;
  logic rsp_valid = 0, rsp_ready; logic [31:0] rsp_data = 0;
  logic cmd_valid, cmd_ready = 0; logic [31:0] cmd_data;
  logic wb_valid; logic [AW-1:0] wb_addr; logic [31:0] wb_data;
  logic [63:0] wptr, rptr; logic empty;

  ring_fetch_ctrl #(.AW(AW), .DBW(DBW), .LGW(LGW)) i_ring_fetch_ctrl (.*);

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  int unsigned lfsr = 32'hACE1_1234;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference
  longint m_base, m_lo, m_wptr, m_rptr, m_wba, m_req_addr;
  int m_lg, m_state, m_dbidx; bit m_dben, m_wbv; longint m_wbd;
  bit got_req, got_rsp;

  always @(posedge clk) begin
    longint n_wptr; bit wait_st;
    got_req = req_valid && req_ready;
    got_rsp = rsp_valid && rsp_ready;
    if (!rst_n) begin
      m_base = 0; m_lo = 0; m_wptr = 0; m_rptr = 0; m_wba = 0; m_req_addr = 0;
      m_lg = 0; m_state = 0; m_dbidx = 0; m_dben = 0; m_wbv = 0; m_wbd = 0;
    end else begin
      wait_st = (m_state == 2);
      n_wptr = m_wptr;
      m_wbv = 0;
      if (m_state == 0 && m_rptr != m_wptr) begin
        m_req_addr = (m_base + ((m_rptr & ((64'd1 << m_lg) - 1)) << 2)) & AMASK;
        m_state = 1;
      end else if (m_state == 1 && req_ready) m_state = 2;
      else if (wait_st && rsp_valid && cmd_ready) begin
        m_rptr++; m_wbv = 1; m_wbd = m_rptr & 64'hFFFF_FFFF; m_state = 0;
      end
      if (reg_we) begin
        case (reg_addr)
          0: m_base = (m_base & ~64'hFFFF_FFFF) | reg_wdata;
          1: m_base = (m_base & 64'hFFFF_FFFF) | ((longint'(reg_wdata) << 32) & AMASK);
          2: m_lg = reg_wdata % 32;
          3: if (!m_dben) m_lo = reg_wdata;
          4: if (!m_dben) n_wptr = (longint'(reg_wdata) << 32) | m_lo;
          5: m_wba = (m_wba & ~64'hFFFF_FFFF) | reg_wdata;
          6: m_wba = (m_wba & 64'hFFFF_FFFF) | ((longint'(reg_wdata) << 32) & AMASK);
          default: ;
        endcase
      end
      if (db_valid && m_dben && db_index == m_dbidx) n_wptr = db_data;
      if (reg_we && reg_addr == 7) begin
        m_dben = reg_wdata[16]; m_dbidx = reg_wdata[DBW-1:0];
      end
      m_wptr = n_wptr;
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #1;
    cycles++;
    if (rst_n) begin
      chk(rptr == m_rptr, "R8 rptr", rptr, m_rptr);
      chk(wptr == m_wptr, "R3/R4/R5 wptr", wptr, m_wptr);
      chk(empty == (m_rptr == m_wptr), "R2 empty", empty, m_rptr == m_wptr);
      chk(req_valid == (m_state == 1), "R7 req_valid", req_valid, m_state == 1);
      if (m_state == 1) chk(req_addr == m_req_addr, "R6 req_addr", req_addr, m_req_addr);
      chk(wb_valid == m_wbv, "R9 wb_valid", wb_valid, m_wbv);
      if (m_wbv) begin
        chk(wb_data == m_wbd, "R9 wb_data", wb_data, m_wbd);
        chk(wb_addr == m_wba, "R9 wb_addr", wb_addr, m_wba);
      end
      chk(cmd_valid == (rsp_valid && m_state == 2), "R10 cmd_valid", cmd_valid, rsp_valid && m_state == 2);
      chk(rsp_ready == (cmd_ready && m_state == 2), "R10 rsp_ready", rsp_ready, cmd_ready && m_state == 2);
      chk(cmd_data == rsp_data, "R10 cmd_data", cmd_data, rsp_data);
    end
  end

  // memory responder and consumer
  int lat = 0; bit pend = 0;
  always @(negedge clk) begin
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    req_ready = lfsr[3] | lfsr[7];
    cmd_ready = lfsr[5] | lfsr[11];
    if (got_rsp) begin rsp_valid = 0; pend = 0; got_rsp = 0; end
    if (got_req) begin pend = 1; lat = lfsr[2:1]; rsp_data = ~32'(req_addr); got_req = 0; end
    if (pend && !rsp_valid) begin
      if (lat > 0) lat--; else rsp_valid = 1;
    end
  end

  task automatic wr(input int a, input longint d);
    @(negedge clk); reg_we = 1; reg_addr = 3'(a); reg_wdata = 32'(d);
    @(negedge clk); reg_we = 0;
  endtask
  task automatic ring(input int idx, input longint d);
    @(negedge clk); db_valid = 1; db_index = DBW'(idx); db_data = d;
    @(negedge clk); db_valid = 0;
  endtask
  task automatic drain;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (empty && !req_valid && !pend && !rsp_valid) break;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(rptr == 0 && wptr == 0, "R1 pointers", rptr, 0);
    chk(empty && !req_valid && !wb_valid, "R1 idle", {empty, req_valid, wb_valid}, 3'b100);
    rst_n = 1;
    wr(0, 64'h1000_0040); wr(1, 64'h12); wr(2, 3);
    wr(5, 64'h2000_0100); wr(6, 64'h34);
    wr(3, 5);
    @(negedge clk);
    chk(wptr == 0 && empty && !req_valid, "R3 low half alone", wptr, 0);
    wr(4, 0);
    drain();
    chk(rptr == 5, "R8 drained to 5", rptr, 5);
    wr(3, 13); wr(4, 0);
    drain();
    chk(rptr == 13, "R6 wrapped ring drained", rptr, 13);
    wr(7, (1 << 16) | 3);
    ring(4, 20);
    @(negedge clk);
    chk(wptr == 13, "R4 wrong index ignored", wptr, 13);
    wr(3, 30); wr(4, 7);
    @(negedge clk);
    chk(wptr == 13, "R5 register path blocked", wptr, 13);
    ring(3, 20);
    chk(wptr == 20, "R4 doorbell load", wptr, 20);
    drain();
    wr(7, 3);
    ring(3, 40);
    @(negedge clk);
    chk(wptr == 20 && empty, "R4 disabled doorbell ignored", wptr, 20);
    wr(2, 2); wr(0, 64'hFFFF_FFF0);
    wr(3, 31); wr(4, 0);
    drain();
    chk(rptr == 31, "R2 final drain", rptr, 31);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule